// File: doc/BRIEF.md
# Clock Mode and Power-Down Detector

This block reads two dual-purpose control pins of a voice codec front end. A free-running reference clock watches each pin and decides whether the pin is toggling, held high or held low. The first pin either carries the receive bit clock or, when it is tied off, selects the master-clock rate. The second pin either carries the receive master clock or, when it is tied off, requests power-down or hands all converter timing to the transmit master clock.

Each pin passes through a two-stage synchronizer. Its edges are then counted over a fixed window of reference cycles. A window with two or more edges reads as clocked, a window with none reads as static at the sampled level, and a window with exactly one edge is undecided. A new mode is adopted only when two windows in a row give the same definite result. The outputs therefore hold steady while a clock starts, stops or glitches. After reset the block reports power-down and the low-rate, shared-bit-clock mode until the pins have been classified.

Top module: `clk_mode_pd_detector`

## Requirements
- R1: With the select pin held low, `mclk_freq_sel` is 0 (1.536/1.544 MHz) and `rx_bclk_from_tx` is 1.
- R2: With the select pin held high, `mclk_freq_sel` is 1 (2.048 MHz) and `rx_bclk_from_tx` is 1.
- R3: With the select pin toggling, `mclk_freq_sel` is 0 and `rx_bclk_from_tx` is 0, so the pin serves as the receive bit clock.
- R4: With the power-down pin held high, `power_down` is 1 and `dac_tx_mclk` is 0. This includes the case where a clock on that pin stops at a high level.
- R5: With the power-down pin held low, `power_down` is 0 and `dac_tx_mclk` is 1.
- R6: With the power-down pin toggling, `power_down` is 0 and `dac_tx_mclk` is 0.
- R7: Each pin is classified once per window of `WIN` reference cycles, after a two-stage synchronizer. Two or more edges mean clocked. No edge means static at the synchronized level. Exactly one edge gives no decision, so one level change cannot switch the mode within `WIN` cycles of that change.
- R8: The classification used by the outputs changes only at a window end, and only when that window and the one before it produced the same definite result. A disturbance confined to one window leaves the outputs unchanged.
- R9: From reset until the power-down pin's first agreed classification, `power_down` is 1. Until the select pin's first agreed classification, `mclk_freq_sel` is 0 and `rx_bclk_from_tx` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_pin | input | 1 | Asynchronous receive bit-clock / rate-select pin |
| pd_pin | input | 1 | Asynchronous receive master-clock / power-down pin |
| mclk_freq_sel | output | 1 | 0: 1.536/1.544 MHz master clock, 1: 2.048 MHz |
| rx_bclk_from_tx | output | 1 | 1: receive path uses the transmit bit clock |
| power_down | output | 1 | 1: power-down requested |
| dac_tx_mclk | output | 1 | 1: transmit master clock drives all converter timing |

## Verification
The bench goes after the reset window. A design that released power-down after a single window, or at once, would be caught there.

It also drives a short pulse on a static select pin. A detector that did not require two agreeing windows would flip the rate or the bit-clock source on that pulse.

A single level change from low to high tests the undecided one-edge case. Treating that change as clocked or as static too early would switch the mode within one window of the change.

Stopping a running clock at a high level on the power-down pin checks the automatic power-down. A decoder that kept the last clocked result would never assert it.

// File: rtl/cmpd_pkg.sv
package cmpd_pkg;

    typedef enum logic [1:0] {
        PC_STATIC_LO = 2'd0,
        PC_STATIC_HI = 2'd1,
        PC_CLOCKED   = 2'd2,
        PC_UNSURE    = 2'd3
    } pin_class_e;

    typedef enum logic {
        MCLK_1544 = 1'b0,
        MCLK_2048 = 1'b1
    } mclk_freq_e;

    typedef struct packed {
        mclk_freq_e freq;
        logic       share_tx_bclk;
    } sel_mode_t;

    typedef struct packed {
        logic power_down;
        logic tx_mclk_all;
    } pd_mode_t;

    localparam logic [1:0] EDGE_SAT = 2'd2;

    // Verdict for one window from its saturated edge count and final level.
    function automatic pin_class_e classify(input logic [1:0] edges, input logic level);
        if (edges >= EDGE_SAT)
            return PC_CLOCKED;
        else if (edges == 2'd0)
            return level ? PC_STATIC_HI : PC_STATIC_LO;
        else
            return PC_UNSURE;
    endfunction

    function automatic sel_mode_t decode_sel(input pin_class_e c);
        sel_mode_t m;
        case (c)
            PC_CLOCKED:   begin m.freq = MCLK_1544; m.share_tx_bclk = 1'b0; end
            PC_STATIC_HI: begin m.freq = MCLK_2048; m.share_tx_bclk = 1'b1; end
            default:      begin m.freq = MCLK_1544; m.share_tx_bclk = 1'b1; end
        endcase
        return m;
    endfunction

    function automatic pd_mode_t decode_pd(input pin_class_e c);
        pd_mode_t m;
        case (c)
            PC_STATIC_LO: begin m.power_down = 1'b0; m.tx_mclk_all = 1'b1; end
            PC_CLOCKED:   begin m.power_down = 1'b0; m.tx_mclk_all = 1'b0; end
            default:      begin m.power_down = 1'b1; m.tx_mclk_all = 1'b0; end
        endcase
        return m;
    endfunction

endpackage

// File: rtl/cmpd_window_timer.sv
module cmpd_window_timer #(
    parameter int WIN = 16
) (
    input  logic clk,
    input  logic rst,
    output logic win_end
);
    localparam int CW = (WIN > 2) ? $clog2(WIN) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIN - 1);

    logic [CW-1:0] cnt_q;

    assign win_end = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (win_end)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // R7: each window is exactly WIN cycles; the count restarts after its last cycle
    a_r7_window_wrap: assert property (@(posedge clk) disable iff (rst)
        win_end |=> (cnt_q == '0));

endmodule

// File: rtl/cmpd_pin_classifier.sv
module cmpd_pin_classifier
    import cmpd_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter pin_class_e RESET_CLASS = PC_STATIC_LO
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_async,
    input  logic       win_end,
    output pin_class_e committed
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   level_q;
    logic [1:0]             edges_q;
    logic [1:0]             edges_nx;
    logic                   edge_seen;
    pin_class_e             cand_q;
    pin_class_e             cand_now;
    pin_class_e             commit_q;

    // Synchronizer chain, one flop per stage.
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst)
                sync_q[g] <= 1'b0;
            else if (g == 0)
                sync_q[g] <= pin_async;
            else
                sync_q[g] <= sync_q[(g == 0) ? 0 : g - 1];
        end
    end

    assign edge_seen = sync_q[SYNC_STAGES-1] ^ level_q;
    assign edges_nx  = (edge_seen && edges_q != EDGE_SAT) ? edges_q + 2'd1 : edges_q;
    assign cand_now  = classify(edges_nx, sync_q[SYNC_STAGES-1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q  <= 1'b0;
            edges_q  <= 2'd0;
            cand_q   <= PC_UNSURE;
            commit_q <= RESET_CLASS;
        end else begin
            level_q <= sync_q[SYNC_STAGES-1];
            if (win_end) begin
                edges_q <= 2'd0;
                cand_q  <= cand_now;
                if (cand_now == cand_q && cand_now != PC_UNSURE)
                    commit_q <= cand_now;
            end else begin
                edges_q <= edges_nx;
            end
        end
    end

    assign committed = commit_q;

    // R8: the adopted class moves only on the cycle after a window end
    a_r8_commit_at_window_end: assert property (@(posedge clk) disable iff (rst)
        !$stable(commit_q) |-> $past(win_end));

    // R8: a newly adopted class matches the verdict of the previous window
    a_r8_commit_agrees: assert property (@(posedge clk) disable iff (rst)
        !$stable(commit_q) |-> ($past(cand_q) == commit_q));

    // R7: an undecided window is never adopted
    a_r7_no_unsure_commit: assert property (@(posedge clk) disable iff (rst)
        commit_q != PC_UNSURE);

    // R7: the edge counter saturates at two
    a_r7_edge_saturates: assert property (@(posedge clk) disable iff (rst)
        edges_q <= EDGE_SAT);

endmodule

// File: rtl/clk_mode_pd_detector.sv
module clk_mode_pd_detector
    import cmpd_pkg::*;
#(
    parameter int WIN         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_pin,
    input  logic pd_pin,
    output logic mclk_freq_sel,
    output logic rx_bclk_from_tx,
    output logic power_down,
    output logic dac_tx_mclk
);
    logic       win_end;
    pin_class_e sel_class;
    pin_class_e pd_class;
    sel_mode_t  sel_mode;
    pd_mode_t   pd_mode;

    cmpd_window_timer #(.WIN(WIN)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .win_end (win_end)
    );

    cmpd_pin_classifier #(
        .SYNC_STAGES (SYNC_STAGES),
        .RESET_CLASS (PC_STATIC_LO)
    ) u_sel_cls (
        .clk       (clk),
        .rst       (rst),
        .pin_async (sel_pin),
        .win_end   (win_end),
        .committed (sel_class)
    );

    cmpd_pin_classifier #(
        .SYNC_STAGES (SYNC_STAGES),
        .RESET_CLASS (PC_STATIC_HI)
    ) u_pd_cls (
        .clk       (clk),
        .rst       (rst),
        .pin_async (pd_pin),
        .win_end   (win_end),
        .committed (pd_class)
    );

    always_comb begin
        sel_mode = decode_sel(sel_class);
        pd_mode  = decode_pd(pd_class);
    end

    assign mclk_freq_sel   = sel_mode.freq;
    assign rx_bclk_from_tx = sel_mode.share_tx_bclk;
    assign power_down      = pd_mode.power_down;
    assign dac_tx_mclk     = pd_mode.tx_mclk_all;

    // R9: power-down holds on the first cycle out of reset
    a_r9_pd_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> power_down);

    // R5: converter timing is never handed over while powered down
    a_r5_tx_mclk_not_in_pd: assert property (@(posedge clk) disable iff (rst)
        dac_tx_mclk |-> !power_down);

    // R3: a clocked select pin never selects the high rate
    a_r3_clocked_low_rate: assert property (@(posedge clk) disable iff (rst)
        !rx_bclk_from_tx |-> !mclk_freq_sel);

endmodule

// File: tb/test_clk_mode_pd_detector.sv
module test_clk_mode_pd_detector;
    localparam int WIN = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel_pin;
    logic pd_pin;
    logic mclk_freq_sel, rx_bclk_from_tx, power_down, dac_tx_mclk;

    // pin drive mode: 0 held low, 1 held high, 2 toggling
    int sel_mode = 0;
    int pd_mode  = 0;
    logic sel_force_en = 1'b0;
    logic sel_force_val = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    clk_mode_pd_detector #(.WIN(WIN)) i_clk_mode_pd_detector (
        .clk             (clk),
        .rst             (rst),
        .sel_pin         (sel_pin),
        .pd_pin          (pd_pin),
        .mclk_freq_sel   (mclk_freq_sel),
        .rx_bclk_from_tx (rx_bclk_from_tx),
        .power_down      (power_down),
        .dac_tx_mclk     (dac_tx_mclk)
    );

    // Pin driver: changes happen only on falling edges.
    initial begin
        int ph;
        ph = 0;
        sel_pin = 1'b0;
        pd_pin  = 1'b0;
        forever begin
            @(negedge clk);
            ph = (ph + 1) % 6;
            if (sel_force_en)       sel_pin = sel_force_val;
            else if (sel_mode == 2) sel_pin = (ph < 3);
            else                    sel_pin = (sel_mode == 1);
            if (pd_mode == 2)       pd_pin = (ph >= 3);
            else                    pd_pin = (pd_mode == 1);
        end
    end

    task automatic check(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic f, input logic s, input logic p, input logic d);
        check(req, mclk_freq_sel,   f, "mclk_freq_sel");
        check(req, rx_bclk_from_tx, s, "rx_bclk_from_tx");
        check(req, power_down,      p, "power_down");
        check(req, dac_tx_mclk,     d, "dac_tx_mclk");
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset_window();
        sel_mode = 0; pd_mode = 0;
        rst = 1'b1;
        wait_cycles(4);
        rst = 1'b0;
        wait_cycles(1);
        check_all("R9", 1'b0, 1'b1, 1'b1, 1'b0);      // R9 reset state
        wait_cycles(WIN + 3);
        check("R9", power_down, 1'b1, "power_down after one window");
        wait_cycles(3 * WIN);
        check_all("R5", 1'b0, 1'b1, 1'b0, 1'b1);      // R1 and R5 both held low
        check("R1", rx_bclk_from_tx, 1'b1, "select low shares bit clock");
    endtask

    task automatic t_sel_high_single_edge();
        sel_mode = 1;                                  // one edge only
        wait_cycles(WIN);
        check("R7", mclk_freq_sel, 1'b0, "rate still low one window after change");
        wait_cycles(3 * WIN);
        check_all("R2", 1'b1, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_sel_clocked();
        sel_mode = 2;
        wait_cycles(4 * WIN);
        check_all("R3", 1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_pd_clocked_then_stop();
        pd_mode = 2;
        wait_cycles(4 * WIN);
        check_all("R6", 1'b0, 1'b0, 1'b0, 1'b0);
        pd_mode = 1;                                   // clock stops high
        wait_cycles(4 * WIN);
        check_all("R4", 1'b0, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_sel_glitch();
        int bad;
        sel_mode = 0; pd_mode = 0;
        wait_cycles(4 * WIN);
        check_all("R1", 1'b0, 1'b1, 1'b0, 1'b1);
        bad = 0;
        sel_force_val = 1'b1; sel_force_en = 1'b1;
        wait_cycles(2);
        sel_force_val = 1'b0;
        wait_cycles(1);
        sel_force_en = 1'b0;
        for (int i = 0; i < 4 * WIN; i++) begin
            @(negedge clk);
            if (mclk_freq_sel !== 1'b0 || rx_bclk_from_tx !== 1'b1) bad++;
        end
        check("R8", (bad == 0), 1'b1, "outputs steady across short pulse");
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset_window();
        t_sel_high_single_edge();
        t_sel_clocked();
        t_pd_clocked_then_stop();
        t_sel_glitch();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule